// File: doc/BRIEF.md
# Fetch-and-Add Execution Unit

This unit carries out a swap-and-add operation. It takes a source register value and a destination operand. The destination gets the sum of the two. The source register gets back the old destination value. Six arithmetic flags are produced from the sum. The destination is either a register-file entry, whose value arrives on an input port, or a memory word reached through a request/acknowledge port. When the destination is in memory, the unit runs a read, then an add step, then a write. It can hold a lock output across that whole sequence, so that no other agent can come between the read and the write.

Before it commits anything, the unit checks three things: that the operand width is legal, that a lock is only requested for a memory destination, and that the access is aligned when alignment checking applies. A failed check ends the operation with a fault code and no state change. Register-destination operations finish one cycle after `start`. Memory operations finish one cycle after the write is acknowledged.

Top module: `fetch_add_unit`

## Requirements
- R1: The effective width comes from `byte_op`, `wide_flag`, `long_mode` and `word_op`, checked in that order:
  - `byte_op` selects 8 bits, even when `wide_flag` is set.
  - Otherwise, `wide_flag` together with `long_mode` selects 64 bits.
  - Otherwise, `word_op` selects 16 bits.
  - Otherwise the width is 32 bits, in both modes.
  - `mem_size` encodes the width as 0=8, 1=16, 2=32, 3=64.
- R2: If `wide_flag` is set without `long_mode` and `byte_op` is clear, the operation ends with `fault`=1 and `fault_code`=3. No register, flag or memory write is made.
- R3: For a register destination with no fault, `done` pulses one cycle after `start`. In that cycle:
  - `dst_we`=1, and `dst_wdata` carries the sum at the selected width.
  - `src_we`=1, and `src_wdata` carries the old destination value.
- R4: `flags` is laid out as bit0 carry, bit1 parity, bit2 auxiliary carry, bit3 zero, bit4 sign, bit5 overflow. It is written with `flags_we` and taken from the sum at the selected width:
  - Carry is the carry out of the top bit.
  - Parity is 1 when the low 8 result bits hold an even number of ones.
  - Auxiliary carry is the carry out of bit 3.
  - Zero is 1 when the result is 0, and sign is the result's top bit.
  - Overflow is set when both operands share a sign that differs from the result's sign.
- R5: Register writes of 8- and 16-bit results keep bits above the width from the register's old value. 32-bit results are zero-extended to 64 bits.
- R6: When `same_reg` is set for a register destination, only `dst_we` is raised, and that register receives the sum.
- R7: For a memory destination, the unit first issues a read (`mem_req`=1, `mem_we`=0) at `addr`. It then writes the sum, zero-extended, to the same address. `done` pulses the cycle after the write `mem_ack`, together with `src_we`, which carries the read value merged per R5. `dst_we` stays 0.
- R8: With `lock_req` and a memory destination, `mem_lock` is 1 from the read request until the write acknowledge. Without `lock_req`, `mem_lock` stays 0.
- R9: If `lock_req` is set with a register destination, the operation ends with `fault`=1 and `fault_code`=1, and nothing is written.
- R10: If `align_chk`=1, `cpl`=3 and `addr` is not a multiple of the operand size in bytes, a memory operation ends with `fault_code`=2 and no memory request. When `cpl` is not 3, the same address proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (taken while idle) |
| byte_op | input | 1 | 8-bit operation form |
| word_op | input | 1 | 16-bit size override |
| wide_flag | input | 1 | Width promotion to 64 bits |
| long_mode | input | 1 | Processor is in 64-bit mode |
| lock_req | input | 1 | Atomic operation requested |
| dst_is_mem | input | 1 | Destination is in memory |
| same_reg | input | 1 | Source and destination name one register |
| align_chk | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| src_val | input | 64 | Source register value |
| dst_val | input | 64 | Destination register value |
| addr | input | ADDR_W | Destination memory address |
| done | output | 1 | Operation finished (one-cycle pulse) |
| fault | output | 1 | Last operation faulted |
| fault_code | output | 2 | 1 lock misuse, 2 misaligned, 3 illegal width |
| src_we | output | 1 | Source register write enable |
| src_wdata | output | 64 | New source register value |
| dst_we | output | 1 | Destination register write enable |
| dst_wdata | output | 64 | New destination register value |
| flags_we | output | 1 | Flags write enable |
| flags | output | 6 | Arithmetic flags |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 64 | Memory write data |
| mem_size | output | 2 | Access size code |
| mem_lock | output | 1 | Atomic lock held |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Memory read data |

## Verification
The adder and flags are tried with the following operand pairs, each at a different width:
- a byte pair that wraps to zero, which separates carry, zero and overflow;
- a 16-bit signed wrap, which raises overflow, sign and auxiliary carry without carry;
- an all-ones 64-bit increment;
- plain 32-bit sums in and out of 64-bit mode.

Register operands carry patterned upper bits, so any failure to preserve or zero-extend them shows up. Memory operations run with different acknowledge latencies, with and without the lock, to separate the lock span from request timing. Aligned and misaligned addresses at privilege levels 3 and 0 show that the alignment fault depends on both conditions.

// File: rtl/fetch_add_unit.sv
module fetch_add_unit #(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_op,
  input  logic              word_op,
  input  logic              wide_flag,
  input  logic              long_mode,
  input  logic              lock_req,
  input  logic              dst_is_mem,
  input  logic              same_reg,
  input  logic              align_chk,
  input  logic [1:0]        cpl,
  input  logic [63:0]       src_val,
  input  logic [63:0]       dst_val,
  input  logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic              src_we,
  output logic [63:0]       src_wdata,
  output logic              dst_we,
  output logic [63:0]       dst_wdata,
  output logic              flags_we,
  output logic [5:0]        flags,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [1:0]        mem_size,
  output logic              mem_lock,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata
);

  typedef enum logic [1:0] {IDLE, RD, CALC, WR} st_t;
  st_t st;

  logic [1:0]  sz_q;
  logic [63:0] src_q, old_q;

  function automatic logic [63:0] width_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic top_bit(logic [63:0] v, logic [1:0] sz);
    case (sz)
      2'd0:    return v[7];
      2'd1:    return v[15];
      2'd2:    return v[31];
      default: return v[63];
    endcase
  endfunction

  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] nv, logic [1:0] sz);
    case (sz)
      2'd0:    return {old[63:8], nv[7:0]};
      2'd1:    return {old[63:16], nv[15:0]};
      2'd2:    return {32'd0, nv[31:0]};
      default: return nv;
    endcase
  endfunction

  // request decode
  wire [1:0] sz_in = byte_op ? 2'd0 : (wide_flag && long_mode) ? 2'd3 :
                     word_op ? 2'd1 : 2'd2;
  wire [2:0] amask = (sz_in == 2'd0) ? 3'd0 : (sz_in == 2'd1) ? 3'd1 :
                     (sz_in == 2'd2) ? 3'd3 : 3'd7;
  wire width_bad = !byte_op && wide_flag && !long_mode;
  wire lock_bad  = lock_req && !dst_is_mem;
  wire align_bad = dst_is_mem && align_chk && (cpl == 2'd3) && ((addr[2:0] & amask) != 3'd0);
  wire [1:0] fcode_in = width_bad ? 2'd3 : lock_bad ? 2'd1 : align_bad ? 2'd2 : 2'd0;

  // shared adder: idle uses live inputs, memory sequence uses captured values
  wire        idle = (st == IDLE);
  wire [1:0]  op_sz = idle ? sz_in : sz_q;
  wire [63:0] m     = width_mask(op_sz);
  wire [63:0] op_a  = (idle ? src_val : src_q) & m;
  wire [63:0] op_b  = (idle ? dst_val : old_q) & m;
  wire [64:0] s65   = {1'b0, op_a} + {1'b0, op_b};
  wire [63:0] res   = s65[63:0] & m;

  logic cf;
  always_comb begin
    case (op_sz)
      2'd0:    cf = s65[8];
      2'd1:    cf = s65[16];
      2'd2:    cf = s65[32];
      default: cf = s65[64];
    endcase
  end

  wire sa = top_bit(op_a, op_sz);
  wire sb = top_bit(op_b, op_sz);
  wire sr = top_bit(res, op_sz);
  wire [5:0] fl = {(sa == sb) && (sr != sa), sr, res == 64'd0,
                   op_a[4] ^ op_b[4] ^ res[4], ~^res[7:0], cf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      done <= 1'b0;
      fault <= 1'b0;
      fault_code <= 2'd0;
      src_we <= 1'b0;
      dst_we <= 1'b0;
      flags_we <= 1'b0;
      src_wdata <= '0;
      dst_wdata <= '0;
      flags <= '0;
      mem_req <= 1'b0;
      mem_we <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= '0;
      mem_size <= '0;
      mem_lock <= 1'b0;
      sz_q <= '0;
      src_q <= '0;
      old_q <= '0;
    end else begin
      done <= 1'b0;
      src_we <= 1'b0;
      dst_we <= 1'b0;
      flags_we <= 1'b0;
      case (st)
        IDLE: if (start) begin
          sz_q <= sz_in;
          src_q <= src_val;
          fault <= (fcode_in != 2'd0);
          fault_code <= fcode_in;
          if (fcode_in != 2'd0) begin
            done <= 1'b1;
          end else if (!dst_is_mem) begin
            done <= 1'b1;
            dst_we <= 1'b1;
            dst_wdata <= merge(dst_val, res, sz_in);
            src_we <= !same_reg;
            src_wdata <= merge(src_val, dst_val, sz_in);
            flags_we <= 1'b1;
            flags <= fl;
          end else begin
            st <= RD;
            mem_req <= 1'b1;
            mem_we <= 1'b0;
            mem_addr <= addr;
            mem_size <= sz_in;
            mem_lock <= lock_req;
          end
        end
        RD: if (mem_ack) begin
          old_q <= mem_rdata;
          mem_req <= 1'b0;
          st <= CALC;
        end
        CALC: begin
          mem_wdata <= res;
          flags <= fl;
          mem_req <= 1'b1;
          mem_we <= 1'b1;
          st <= WR;
        end
        default: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we <= 1'b0;
          mem_lock <= 1'b0;
          done <= 1'b1;
          src_we <= 1'b1;
          src_wdata <= merge(src_q, old_q, sz_q);
          flags_we <= 1'b1;
          st <= IDLE;
        end
      endcase
    end
  end

  assert_lock_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> (st != IDLE));
  assert_lock_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WR && mem_ack) |=> (done && !mem_lock));
  assert_reg_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && !dst_is_mem) |=> done);
  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> !(src_we || dst_we || flags_we));
  assert_no_mem_on_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && fcode_in != 2'd0) |=> !mem_req);
  assert_same_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && !dst_is_mem && same_reg && fcode_in == 2'd0) |=> (dst_we && !src_we));
  assert_mem_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && mem_we) |-> 1'b0);

endmodule

// File: tb/fetch_add_unit_tb.sv
module fetch_add_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 48;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic byte_op = 0, word_op = 0, wide_flag = 0, long_mode = 0, lock_req = 0;
  logic dst_is_mem = 0, same_reg = 0, align_chk = 0;
  logic [1:0] cpl = 0;
  logic [63:0] src_val = 0, dst_val = 0;
  logic [ADDR_W-1:0] addr = 0;
  logic done, fault, src_we, dst_we, flags_we, mem_req, mem_we, mem_lock;
  logic [1:0] fault_code, mem_size;
  logic [63:0] src_wdata, dst_wdata, mem_wdata;
  logic [5:0] flags;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [63:0] mem_rdata = 0;

  int n_tests = 0, n_fail = 0;
  logic [63:0] mem_word = 0;
  logic [ADDR_W-1:0] rd_addr = 0, wr_addr = 0;
  int lat = 0, cnt = 0, rd_cnt = 0, wr_cnt = 0, lock_hi = 0, lock_lo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_add_unit #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_op(byte_op), .word_op(word_op),
    .wide_flag(wide_flag), .long_mode(long_mode), .lock_req(lock_req),
    .dst_is_mem(dst_is_mem), .same_reg(same_reg), .align_chk(align_chk), .cpl(cpl),
    .src_val(src_val), .dst_val(dst_val), .addr(addr), .done(done), .fault(fault),
    .fault_code(fault_code), .src_we(src_we), .src_wdata(src_wdata), .dst_we(dst_we),
    .dst_wdata(dst_wdata), .flags_we(flags_we), .flags(flags), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_size(mem_size),
    .mem_lock(mem_lock), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  // memory model with programmable acknowledge latency
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req) begin
      if (mem_lock) lock_hi <= lock_hi + 1;
      else lock_lo <= lock_lo + 1;
    end
    if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem_word <= mem_wdata;
          wr_addr <= mem_addr;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= mem_word;
          rd_addr <= mem_addr;
          rd_cnt <= rd_cnt + 1;
        end
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] wmask(int sz);
    return (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic logic [5:0] exp_flags(logic [63:0] a, logic [63:0] b, int sz);
    int w;
    logic [63:0] mk, r;
    logic [64:0] s;
    logic sa, sb, sr;
    w = 8 << sz;
    mk = wmask(sz);
    s = {1'b0, a & mk} + {1'b0, b & mk};
    r = s[63:0] & mk;
    sa = a[w-1]; sb = b[w-1]; sr = r[w-1];
    return {(sa == sb) && (sr != sa), sr, r == 64'd0, a[4] ^ b[4] ^ r[4], ~^r[7:0], s[w]};
  endfunction

  function automatic logic [63:0] exp_merge(logic [63:0] old, logic [63:0] nv, int sz);
    if (sz == 2) return nv & wmask(2);
    return (old & ~wmask(sz)) | (nv & wmask(sz));
  endfunction

  task automatic set_ops(input logic b, input logic w, input logic wd, input logic lg);
    byte_op = b; word_op = w; wide_flag = wd; long_mode = lg;
  endtask

  task automatic reg_case(input string tag, input logic b, input logic w, input logic wd,
                          input logic lg, input logic same, input logic [63:0] s,
                          input logic [63:0] d, input int esz);
    logic [63:0] sum;
    sum = (s + d) & wmask(esz);
    set_ops(b, w, wd, lg);
    lock_req = 0; dst_is_mem = 0; same_reg = same; src_val = s; dst_val = d;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(done === 1'b1, "R3", {tag, " done after one cycle"}, done, 1);
    chk(fault === 1'b0, "R3", {tag, " no fault"}, fault, 0);
    chk(dst_we === 1'b1, "R3", {tag, " dst_we"}, dst_we, 1);
    chk(dst_wdata === exp_merge(d, sum, esz), "R5", {tag, " dst_wdata"}, dst_wdata, exp_merge(d, sum, esz));
    chk(flags_we === 1'b1 && flags === exp_flags(s, d, esz), "R4", {tag, " flags"},
        {58'd0, flags}, {58'd0, exp_flags(s, d, esz)});
    if (same) begin
      chk(src_we === 1'b0, "R6", {tag, " src_we suppressed"}, src_we, 0);
    end else begin
      chk(src_we === 1'b1, "R3", {tag, " src_we"}, src_we, 1);
      chk(src_wdata === exp_merge(s, d, esz), "R3", {tag, " src_wdata old dst"},
          src_wdata, exp_merge(s, d, esz));
    end
    @(negedge clk);
    chk(done === 1'b0, "R3", {tag, " done is a pulse"}, done, 0);
    same_reg = 0;
  endtask

  task automatic fault_case(input string req, input string tag, input logic mem,
                            input logic lk, input logic [ADDR_W-1:0] a, input logic [1:0] code);
    int rd0;
    logic [63:0] mw0;
    rd0 = rd_cnt;
    mw0 = mem_word;
    lock_req = lk; dst_is_mem = mem; addr = a; src_val = 64'h11; dst_val = 64'h22;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(done === 1'b1 && fault === 1'b1, req, {tag, " fault done"}, {62'd0, done, fault}, 3);
    chk(fault_code === code, req, {tag, " fault_code"}, {62'd0, fault_code}, {62'd0, code});
    chk(!src_we && !dst_we && !flags_we, req, {tag, " no writes"},
        {61'd0, src_we, dst_we, flags_we}, 0);
    repeat (4) @(negedge clk);
    chk(mem_req === 1'b0 && rd_cnt == rd0, req, {tag, " no memory access"},
        64'(rd_cnt - rd0), 0);
    chk(mem_word === mw0, req, {tag, " memory unchanged"}, mem_word, mw0);
    lock_req = 0; dst_is_mem = 0;
  endtask

  task automatic mem_case(input string tag, input logic lk, input logic [63:0] s,
                          input logic [63:0] mv, input logic [ADDR_W-1:0] a,
                          input int esz, input int latency);
    int n;
    logic [63:0] sum;
    sum = (s + mv) & wmask(esz);
    mem_word = mv; lat = latency; lock_hi = 0; lock_lo = 0;
    rd_cnt = 0; wr_cnt = 0;
    lock_req = lk; dst_is_mem = 1; addr = a; src_val = s; dst_val = 64'hDEAD;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(mem_req === 1'b1 && mem_we === 1'b0, "R7", {tag, " read issued"},
        {62'd0, mem_req, mem_we}, 2);
    chk(mem_size === 2'(esz), "R1", {tag, " mem_size"}, {62'd0, mem_size}, 64'(esz));
    n = 0;
    while (done !== 1'b1 && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1 && fault === 1'b0, "R7", {tag, " done"}, {62'd0, done, fault}, 2);
    chk(rd_cnt == 1 && wr_cnt == 1, "R7", {tag, " one read one write"},
        64'(rd_cnt * 16 + wr_cnt), 17);
    chk(rd_addr === a && wr_addr === a, "R7", {tag, " address"}, 64'(wr_addr), 64'(a));
    chk(mem_word === sum, "R7", {tag, " memory sum"}, mem_word, sum);
    chk(src_we === 1'b1 && src_wdata === exp_merge(s, mv, esz), "R7", {tag, " src gets old"},
        src_wdata, exp_merge(s, mv, esz));
    chk(dst_we === 1'b0, "R7", {tag, " no dst reg write"}, dst_we, 0);
    chk(flags_we === 1'b1 && flags === exp_flags(s, mv, esz), "R4", {tag, " flags"},
        {58'd0, flags}, {58'd0, exp_flags(s, mv, esz)});
    if (lk) chk(lock_lo == 0 && lock_hi > 0 && mem_lock === 1'b0, "R8", {tag, " lock span"},
                64'(lock_lo), 0);
    else chk(lock_hi == 0, "R8", {tag, " no lock"}, 64'(lock_hi), 0);
    @(negedge clk);
    lock_req = 0; dst_is_mem = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && mem_req === 1'b0 && mem_lock === 1'b0, "R3", "reset state",
        {61'd0, done, mem_req, mem_lock}, 0);
    rst_n = 1;
    @(negedge clk);

    reg_case("R1 dword long", 0, 0, 0, 1, 0, 64'hFFFF_0000_0000_0005, 64'hABCD_0000_0000_0007, 2);
    reg_case("R1 dword legacy", 0, 0, 0, 0, 0, 64'h0000_0000_8000_0000, 64'h1234_5678_8000_0000, 2);
    reg_case("R5 byte wrap", 1, 0, 0, 1, 0, 64'hAAAA_AAAA_AAAA_AA80, 64'h5555_5555_5555_5580, 0);
    reg_case("R1 byte over wide", 1, 0, 1, 0, 0, 64'h0123_4567_89AB_CD0F, 64'hFEDC_BA98_7654_3201, 0);
    reg_case("R5 word signed wrap", 0, 1, 0, 1, 0, 64'h1111_2222_3333_7FFF, 64'h4444_5555_6666_0001, 1);
    reg_case("R1 qword", 0, 1, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 3);
    reg_case("R6 same register", 0, 0, 0, 1, 1, 64'h0000_0000_0000_0030, 64'h0000_0000_0000_0030, 2);

    set_ops(0, 0, 1, 0);
    fault_case("R2", "R2 wide outside long", 0, 0, '0, 2'd3);
    set_ops(0, 0, 0, 1);
    fault_case("R9", "R9 lock on register", 0, 1, '0, 2'd1);

    set_ops(0, 0, 0, 1);
    align_chk = 1; cpl = 2'd3;
    fault_case("R10", "R10 misaligned cpl3", 1, 1, 48'h1002, 2'd2);

    mem_case("R8 locked dword", 1, 64'h0000_0000_0000_0010, 64'h0000_0000_FFFF_FFF8, 48'h2000, 2, 2);
    set_ops(0, 1, 1, 1);
    mem_case("R7 unlocked qword", 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 48'h3008, 3, 0);
    set_ops(1, 0, 0, 1);
    mem_case("R7 byte odd addr", 1, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0000_0000_0000_0001, 48'h4003, 0, 3);

    set_ops(0, 0, 0, 1);
    cpl = 2'd0;
    mem_case("R10 misaligned cpl0", 1, 64'h0000_0000_0000_0001, 64'h0000_0000_7FFF_FFFF, 48'h5002, 2, 1);
    align_chk = 0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule